// File: doc/BRIEF.md
# Time-Multiplexed Single-Port Register File

This block is a small processor register file that performs one write and one read in every clock cycle, even though its storage columns have only a single address input. Each clock period is split in two halves. While the clock is low, the shared address carries the write address, and a pending write lands on the rising edge. While the clock is high, the same address carries the read address, and the selected word is captured into the output register on the falling edge.

The storage is built as a set of independent one-bit columns, one per data bit, each with its own single-port array. A pipeline stage issues a write (enable, address, data) and a read address every cycle. The read result is available from just after the falling edge until the next falling edge. Both ports are serviced every cycle, so the block never applies back-pressure: the write enable acts as a valid flag, and there is no ready signal because acceptance is unconditional.

Top module: `tmrf_regfile`

## Requirements
- R1: The array columns see one shared address. It equals the write address while the clock is low and the read address while the clock is high. One write and one read are completed in every cycle, without stalls.
- R2: When `wr_en` is 1, `wr_data` is stored at `wr_addr` on the rising clock edge.
- R3: On each falling edge, `rd_data` loads the word stored at `rd_addr`. It then holds that value until the next falling edge.
- R4: When `wr_en` is 1 and `wr_addr` equals `rd_addr` in the same cycle, `rd_data` returns the newly written `wr_data`.
- R5: When `wr_en` is 0, no entry changes. The read in that cycle still takes place and returns the stored value, even at the address presented on `wr_addr`.
- R6: When `rst` is 1 at a falling edge, `rd_data` becomes 0 at that edge.
- R7: Reset does not clear the array. A word written before reset reads back unchanged after reset is released.
- R8: Each of the 32 data bits is stored independently. Single-bit patterns at any bit position, and their complements, read back exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Low half: write phase. High half: read phase. |
| rst | input | 1 | Synchronous reset of the output register, sampled on the falling edge |
| wr_en | input | 1 | Write enable (valid flag) for the current cycle |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Registered read data, updated on the falling edge |

## Verification
A short vector table is tried first. It covers a same-address write and read, a write to one entry while another is read, and a disabled write aimed at the entry being read. Together these separate the cases of newer data, older data and unchanged data. A long random stream follows, with a forced collision every fourth cycle and walking-one and walking-zero data. The stream exposes a wrong phase selection of the address, a capture taken on the wrong edge, and crosstalk between bit columns. Directed reset cases show that only the output register is cleared and the stored words are kept.

// File: rtl/tmrf_pkg.sv
package tmrf_pkg;
  parameter int unsigned RF_DEPTH = 16;
  parameter int unsigned RF_WIDTH = 32;

  typedef enum logic {
    PH_WRITE = 1'b0,
    PH_READ  = 1'b1
  } phase_e;

  function automatic phase_e phase_of(input logic clk_level);
    return clk_level ? PH_READ : PH_WRITE;
  endfunction
endpackage

// File: rtl/tmrf_port_mux.sv
module tmrf_port_mux #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] port_addr,
  output logic [AW-1:0] wr_idx,
  output logic [AW-1:0] rd_idx
);
  import tmrf_pkg::*;

  phase_e phase;

  always_comb begin
    phase     = phase_of(clk);
    port_addr = (phase == PH_READ) ? rd_addr : wr_addr;
  end

  // The shared address is held for each half-cycle so the edge that ends
  // a phase still sees that phase's address.
  always_latch begin
    if (!clk) wr_idx = port_addr;
  end

  always_latch begin
    if (clk) rd_idx = port_addr;
  end
endmodule

// File: rtl/tmrf_slice.sv
module tmrf_slice #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_idx,
  input  logic [AW-1:0] rd_idx,
  input  logic          din,
  output logic          dout
);
  logic [DEPTH-1:0] cells;

  always_ff @(posedge clk) begin
    if (we) cells[wr_idx] <= din;
  end

  assign dout = cells[rd_idx];
endmodule

// File: rtl/tmrf_capture.sv
module tmrf_capture #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(negedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/tmrf_regfile.sv
module tmrf_regfile #(
  parameter int unsigned DEPTH = tmrf_pkg::RF_DEPTH,
  parameter int unsigned WIDTH = tmrf_pkg::RF_WIDTH,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [AW-1:0]    port_addr;
  logic [AW-1:0]    wr_idx;
  logic [AW-1:0]    rd_idx;
  logic [WIDTH-1:0] col_out;

  tmrf_port_mux #(.AW(AW)) u_mux (
    .clk       (clk),
    .wr_addr   (wr_addr),
    .rd_addr   (rd_addr),
    .port_addr (port_addr),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx)
  );

  // R8: one independent single-port column per data bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_col
    tmrf_slice #(.DEPTH(DEPTH)) u_col (
      .clk    (clk),
      .we     (wr_en),
      .wr_idx (wr_idx),
      .rd_idx (rd_idx),
      .din    (wr_data[b]),
      .dout   (col_out[b])
    );
  end

  tmrf_capture #(.WIDTH(WIDTH)) u_cap (
    .clk (clk),
    .rst (rst),
    .d   (col_out),
    .q   (rd_data)
  );
endmodule

// File: rtl/tmrf_checker.sv
module tmrf_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic [AW-1:0]    rd_addr,
  input logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mdl [DEPTH];
  logic [DEPTH-1:0] seen = '0;
  logic             rst_q = 1'b0;
  logic [WIDTH-1:0] model_rd;

  always @(posedge clk) begin
    if (wr_en) begin
      mdl[wr_addr]  <= wr_data;
      seen[wr_addr] <= 1'b1;
    end
  end

  assign model_rd = mdl[rd_addr];

  always @(negedge clk) rst_q <= rst;

  // R6
  always @(posedge clk) begin
    if (rst_q) begin
      rst_clear_chk: assert (rd_data == '0);
    end
  end

  // R3
  rd_model_chk: assert property (@(negedge clk) disable iff (rst)
    seen[rd_addr] |=> (rd_data == $past(model_rd)));

  // R4
  collision_chk: assert property (@(negedge clk) disable iff (rst)
    (wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)));

  // R5
  hold_chk: assert property (@(negedge clk) disable iff (rst)
    (!wr_en && (wr_addr == rd_addr) && seen[rd_addr])
      |=> (rd_data == $past(model_rd)));
endmodule

bind tmrf_regfile tmrf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_tmrf_regfile.sv
module test_tmrf_regfile;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int AW    = 4;
  localparam int NVEC  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    wr_addr = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [AW-1:0]    rd_addr = '0;
  logic [WIDTH-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [WIDTH-1:0] bm [DEPTH];
  logic [DEPTH-1:0] bm_ok = '0;

  // {we, waddr, wdata, raddr, expected}
  localparam logic [72:0] VEC [NVEC] = '{
    {1'b1, 4'd3,  32'hA5A5_0001, 4'd3,  32'hA5A5_0001},
    {1'b1, 4'd7,  32'h0000_0077, 4'd3,  32'hA5A5_0001},
    {1'b0, 4'd3,  32'hFFFF_FFFF, 4'd3,  32'hA5A5_0001},
    {1'b1, 4'd0,  32'h1234_5678, 4'd7,  32'h0000_0077},
    {1'b1, 4'd15, 32'hDEAD_BEEF, 4'd15, 32'hDEAD_BEEF},
    {1'b1, 4'd3,  32'h0000_0000, 4'd0,  32'h1234_5678},
    {1'b0, 4'd15, 32'h0000_0000, 4'd3,  32'h0000_0000},
    {1'b1, 4'd15, 32'hCAFE_F00D, 4'd15, 32'hCAFE_F00D}
  };

  tmrf_regfile i_tmrf_regfile (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [WIDTH-1:0] got,
                       input logic [WIDTH-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one cycle's inputs just after a falling edge, then wait past the
  // next falling edge, where the read of this cycle has been captured.
  task automatic step(input logic we, input logic [AW-1:0] wa,
                      input logic [WIDTH-1:0] wd, input logic [AW-1:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    if (we) begin
      bm[wa] = wd;
      bm_ok[wa] = 1'b1;
    end
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R6 reset state", rd_data, '0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5: vector table
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][72], VEC[i][71:68], VEC[i][67:36], VEC[i][35:32]);
      check($sformatf("R1 R2 R3 vector %0d", i), rd_data, VEC[i][31:0]);
    end

    // R8 and R4: random stream with walking data and forced collisions
    for (int i = 0; i < 256; i++) begin
      logic             we;
      logic [AW-1:0]    wa, ra;
      logic [WIDTH-1:0] wd;
      logic [WIDTH-1:0] ex;
      we = ($urandom % 4) != 0;
      wa = AW'($urandom);
      ra = (i % 4 == 0) ? wa : AW'($urandom);
      wd = (32'h1 << (i % WIDTH));
      if (i % 3 == 1) wd = ~wd;
      if (i % 5 == 2) wd = $urandom;
      ex = (we && wa == ra) ? wd : bm[ra];
      if (we || bm_ok[ra]) begin
        step(we, wa, wd, ra);
        check((we && wa == ra) ? "R4 collision" : "R8 random read",
              rd_data, ex);
      end else begin
        step(we, wa, wd, ra);
      end
    end

    // R5: disabled write to every entry leaves all contents intact
    for (int a = 0; a < DEPTH; a++) step(1'b1, AW'(a), 32'h5000_0000 + a, AW'(a));
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, AW'(a), 32'hFFFF_0000, AW'(a));
      check("R5 disabled write", rd_data, 32'h5000_0000 + a);
    end

    // R6 R7: reset clears the output only
    step(1'b1, 4'd9, 32'h0BAD_F00D, 4'd2);
    rst = 1'b1;
    step(1'b0, 4'd0, 32'h0, 4'd9);
    check("R6 reset clears output", rd_data, '0);
    rst = 1'b0;
    step(1'b0, 4'd0, 32'h0, 4'd9);
    check("R7 array kept through reset", rd_data, 32'h0BAD_F00D);

    // R3: output holds through the rising edge
    @(posedge clk);
    #1;
    check("R3 hold across rising edge", rd_data, 32'h0BAD_F00D);

    finished = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule